// File: doc/BRIEF.md
# Raster Scanline Timing Generator

This block paces one horizontal raster line for a small bitmap video controller. A free-running position counter advances on every enabled clock. At a fixed set of positions the block compares that count with the current resolution and refresh choice. From those comparisons it drives the border blanking, the horizontal sync pulse, the display window flag and a request to prefill the pixel pipeline.

The two mode inputs are read live, at the moment each decision falls due, not once per line. Software that rewrites them partway through a line can therefore move or suppress the display window and lengthen or shorten the line. The prefill request runs as a short word-counting sequence with one load strobe per four-position word. The display window opens only when that sequence completes.

A line-standard flag is captured once per line from the refresh input. It chooses the line length: 512 positions for the 50 Hz standard, 508 for 60 Hz.

Top module: `scan_timing_gen`

## Requirements
- R1: While reset is applied, and in the first cycle after it, blank_o is 1, hsync_o, de_h_o, preload_o and load_o are 0, and std50_o is 1. Reset is asynchronous and active low, and its release takes effect two clocks later.
- R2: The position counter starts at 0 after reset and wraps to 0 after position 511 when std50_o is 1, or after 507 when it is 0. std50_o takes the value of hz50_i (1 means 50 Hz) sampled at position 56.
- R3: With hires_i at 0 (low resolution), preload_o rises at position 36 if hz50_i is 0 there, or at position 40 if hz50_i is 1 there. A trigger that arrives while preload is already running does not restart it.
- R4: With hires_i at 1 (high resolution), preload_o rises at position 0. The low-resolution trigger positions have no effect in that mode.
- R5: load_o pulses for one enabled cycle at the start of each four-position word, the first at the start of preload. Preload ends at a word boundary once 1 word (high resolution) or 4 words (low resolution) are complete. The limit is read live. de_h_o rises as preload_o falls.
- R6: In low resolution, blank_o clears at position 28 and sets at position 448.
- R7: In low resolution, de_h_o clears at position 372 if hz50_i is 0 there, or at 376 if it is 1, and unconditionally at 460.
- R8: In high resolution, de_h_o clears at position 164 and blank_o sets at position 184.
- R9: In low resolution, hsync_o sets at position 460 and clears at position 500.
- R10: A decision taken at position N shows at the outputs in the cycle after the enabled edge that processed N. With cyc_en low, no output and no position changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Advances the line by one position when high |
| hires_i | input | 1 | 1 = high resolution, 0 = low resolution |
| hz50_i | input | 1 | 1 = 50 Hz refresh, 0 = 60 Hz |
| blank_o | output | 1 | Border blanking |
| hsync_o | output | 1 | Horizontal sync |
| de_h_o | output | 1 | Horizontal display window |
| preload_o | output | 1 | Pipeline prefill request |
| load_o | output | 1 | One strobe per prefill word |
| std50_o | output | 1 | Latched line standard, 1 = 50 Hz (512 positions) |

## Verification
A slipped position counter moves every edge by the same offset, and the error shows within one decision window. A wrong line-standard latch leaves the current line intact. Its four-position error shows only at the first edge of the next line, so the checks sample positions past the wrap in both standards. A miscounted prefill word counter shows within 16 positions, as an extra or missing load strobe and a display window that opens at the wrong position. The mid-line mode switches show whether the mode inputs are read live or held.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

  // One bit per timed decision that fires at the current line position.
  typedef struct packed {
    logic pre_go;    // start the prefill sequence
    logic unblank;   // clear border blanking
    logic blank_on;  // set border blanking
    logic h_off;     // close the display window
    logic sync_on;   // begin horizontal sync
    logic sync_off;  // end horizontal sync
  } line_evt_t;

  typedef enum logic {RES_LOW = 1'b0, RES_HIGH = 1'b1} res_e;

endpackage

// File: rtl/scan_line_counter.sv
module scan_line_counter #(
  parameter int LINE_LONG  = 512,
  parameter int LINE_SHORT = 508,
  parameter int T_STD      = 56,
  localparam int CNT_W     = $clog2(LINE_LONG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             hz50_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             std50_o
);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             std_q, std_d;
  logic [CNT_W-1:0] last_pos;

  always_comb begin
    last_pos = std_q ? CNT_W'(LINE_LONG - 1) : CNT_W'(LINE_SHORT - 1);
    pos_d    = pos_q;
    std_d    = std_q;
    if (cyc_en) begin
      pos_d = (pos_q == last_pos) ? '0 : pos_q + 1'b1;
      if (pos_q == CNT_W'(T_STD)) std_d = hz50_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      std_q <= 1'b1;
    end else begin
      pos_q <= pos_d;
      std_q <= std_d;
    end
  end

  assign pos_o   = pos_q;
  assign std50_o = std_q;

endmodule

// File: rtl/scan_event_decode.sv
module scan_event_decode
  import scan_timing_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int T_HI_PRE     = 0,
  parameter int T_LO_UNBLANK = 28,
  parameter int T_PRE60      = 36,
  parameter int T_PRE50      = 40,
  parameter int T_HI_HOFF    = 164,
  parameter int T_HI_BLANK   = 184,
  parameter int T_HOFF60     = 372,
  parameter int T_HOFF50     = 376,
  parameter int T_LO_BLANK   = 448,
  parameter int T_SYNC_ON    = 460,
  parameter int T_SYNC_OFF   = 500
) (
  input  logic [CNT_W-1:0] pos_i,
  input  res_e             res_i,
  input  logic             hz50_i,
  output line_evt_t        evt_o
);

  logic lo, hi;

  always_comb begin
    hi = (res_i == RES_HIGH);
    lo = (res_i == RES_LOW);

    evt_o.pre_go   = (hi && pos_i == CNT_W'(T_HI_PRE))
                  || (lo && !hz50_i && pos_i == CNT_W'(T_PRE60))
                  || (lo &&  hz50_i && pos_i == CNT_W'(T_PRE50));
    evt_o.unblank  = lo && pos_i == CNT_W'(T_LO_UNBLANK);
    evt_o.blank_on = (lo && pos_i == CNT_W'(T_LO_BLANK))
                  || (hi && pos_i == CNT_W'(T_HI_BLANK));
    evt_o.h_off    = (hi && pos_i == CNT_W'(T_HI_HOFF))
                  || (lo && !hz50_i && pos_i == CNT_W'(T_HOFF60))
                  || (lo &&  hz50_i && pos_i == CNT_W'(T_HOFF50))
                  || (lo && pos_i == CNT_W'(T_SYNC_ON));
    evt_o.sync_on  = lo && pos_i == CNT_W'(T_SYNC_ON);
    evt_o.sync_off = lo && pos_i == CNT_W'(T_SYNC_OFF);
  end

endmodule

// File: rtl/scan_preload_seq.sv
module scan_preload_seq
  import scan_timing_pkg::*;
#(
  parameter int WORD_CYC = 4,
  parameter int WORDS_HI = 1,
  parameter int WORDS_LO = 4,
  localparam int MAXW    = (WORDS_HI > WORDS_LO) ? WORDS_HI : WORDS_LO,
  localparam int PCW     = $clog2(WORD_CYC * MAXW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic start_i,
  input  res_e res_i,
  output logic busy_o,
  output logic load_o,
  output logic done_o
);

  logic           busy_q, busy_d;
  logic           load_q, load_d;
  logic [PCW-1:0] cyc_q, cyc_d;
  logic [PCW-1:0] nxt;
  logic [PCW-1:0] words;
  logic [PCW-1:0] limit;
  logic           word_edge;

  always_comb begin
    nxt       = cyc_q + 1'b1;
    words     = nxt >> $clog2(WORD_CYC);
    limit     = (res_i == RES_HIGH) ? PCW'(WORDS_HI) : PCW'(WORDS_LO);
    word_edge = (nxt & PCW'(WORD_CYC - 1)) == '0;
    busy_d    = busy_q;
    load_d    = load_q;
    cyc_d     = cyc_q;
    done_o    = 1'b0;
    if (cyc_en) begin
      load_d = 1'b0;
      if (busy_q) begin
        if (word_edge && words >= limit) begin
          busy_d = 1'b0;
          cyc_d  = '0;
          done_o = 1'b1;
        end else begin
          cyc_d  = nxt;
          load_d = word_edge;
        end
      end else if (start_i) begin
        busy_d = 1'b1;
        cyc_d  = '0;
        load_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      load_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      load_q <= load_d;
      cyc_q  <= cyc_d;
    end
  end

  assign busy_o = busy_q;
  assign load_o = load_q;

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
#(
  parameter int LINE_LONG    = 512,
  parameter int LINE_SHORT   = 508,
  parameter int T_STD        = 56,
  parameter int T_HI_PRE     = 0,
  parameter int T_LO_UNBLANK = 28,
  parameter int T_PRE60      = 36,
  parameter int T_PRE50      = 40,
  parameter int T_HI_HOFF    = 164,
  parameter int T_HI_BLANK   = 184,
  parameter int T_HOFF60     = 372,
  parameter int T_HOFF50     = 376,
  parameter int T_LO_BLANK   = 448,
  parameter int T_SYNC_ON    = 460,
  parameter int T_SYNC_OFF   = 500,
  parameter int WORD_CYC     = 4,
  parameter int WORDS_HI     = 1,
  parameter int WORDS_LO     = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = $clog2(LINE_LONG)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic hires_i,
  input  logic hz50_i,
  output logic blank_o,
  output logic hsync_o,
  output logic de_h_o,
  output logic preload_o,
  output logic load_o,
  output logic std50_o
);

  // Reset: asserted at once, released through a short flop chain.
  logic [SYNC_STAGES-1:0] rst_chain_q;
  logic                   rst_int_n;

  generate
    if (SYNC_STAGES == 1) begin : g_rs_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_chain_q <= '0;
        else        rst_chain_q <= 1'b1;
      end
    end else begin : g_rs_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_chain_q <= '0;
        else        rst_chain_q <= {rst_chain_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_chain_q[SYNC_STAGES-1];

  res_e             res;
  logic [CNT_W-1:0] pos;
  line_evt_t        evt;
  logic             pre_done;

  assign res = hires_i ? RES_HIGH : RES_LOW;

  scan_line_counter #(
    .LINE_LONG (LINE_LONG),
    .LINE_SHORT(LINE_SHORT),
    .T_STD     (T_STD)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cyc_en (cyc_en),
    .hz50_i (hz50_i),
    .pos_o  (pos),
    .std50_o(std50_o)
  );

  scan_event_decode #(
    .CNT_W       (CNT_W),
    .T_HI_PRE    (T_HI_PRE),
    .T_LO_UNBLANK(T_LO_UNBLANK),
    .T_PRE60     (T_PRE60),
    .T_PRE50     (T_PRE50),
    .T_HI_HOFF   (T_HI_HOFF),
    .T_HI_BLANK  (T_HI_BLANK),
    .T_HOFF60    (T_HOFF60),
    .T_HOFF50    (T_HOFF50),
    .T_LO_BLANK  (T_LO_BLANK),
    .T_SYNC_ON   (T_SYNC_ON),
    .T_SYNC_OFF  (T_SYNC_OFF)
  ) u_decode (
    .pos_i (pos),
    .res_i (res),
    .hz50_i(hz50_i),
    .evt_o (evt)
  );

  scan_preload_seq #(
    .WORD_CYC(WORD_CYC),
    .WORDS_HI(WORDS_HI),
    .WORDS_LO(WORDS_LO)
  ) u_preload (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cyc_en (cyc_en),
    .start_i(evt.pre_go),
    .res_i  (res),
    .busy_o (preload_o),
    .load_o (load_o),
    .done_o (pre_done)
  );

  // Output flags: next-state logic, then registers.
  logic blank_q, blank_d;
  logic sync_q,  sync_d;
  logic h_q,     h_d;

  always_comb begin
    blank_d = blank_q;
    sync_d  = sync_q;
    h_d     = h_q;
    if (cyc_en) begin
      if (evt.blank_on)     blank_d = 1'b1;
      else if (evt.unblank) blank_d = 1'b0;
      if (evt.sync_on)       sync_d = 1'b1;
      else if (evt.sync_off) sync_d = 1'b0;
      if (evt.h_off)     h_d = 1'b0;
      else if (pre_done) h_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      blank_q <= 1'b1;
      sync_q  <= 1'b0;
      h_q     <= 1'b0;
    end else begin
      blank_q <= blank_d;
      sync_q  <= sync_d;
      h_q     <= h_d;
    end
  end

  assign blank_o = blank_q;
  assign hsync_o = sync_q;
  assign de_h_o  = h_q;

endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_en,
  input logic hires_i,
  input logic blank_o,
  input logic hsync_o,
  input logic de_h_o,
  input logic preload_o,
  input logic load_o,
  input logic std50_o
);

  // R5: a word strobe only appears while prefill is running
  a_r5_load_inside_preload: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> preload_o);

  // R5: each strobe lasts exactly one enabled cycle
  a_r5_load_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && cyc_en) |=> !load_o);

  // R5: the display window opens only as prefill finishes
  a_r5_h_opens_after_preload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_h_o) |-> $fell(preload_o));

  // R9: sync begins only from a low-resolution enabled cycle
  a_r9_sync_low_res: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_o) |-> $past(cyc_en && !hires_i));

  // R10: nothing moves without the enable
  a_r10_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable({blank_o, hsync_o, de_h_o, preload_o, load_o, std50_o}));

endmodule

bind scan_timing_gen scan_timing_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_en   (cyc_en),
  .hires_i  (hires_i),
  .blank_o  (blank_o),
  .hsync_o  (hsync_o),
  .de_h_o   (de_h_o),
  .preload_o(preload_o),
  .load_o   (load_o),
  .std50_o  (std50_o)
);

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb;

  logic clk = 1'b0;
  logic rst_n, cyc_en, hires_i, hz50_i;
  logic blank_o, hsync_o, de_h_o, preload_o, load_o, std50_o;

  int checks = 0;
  int errors = 0;
  int pos    = 0;

  always #2.5 clk = ~clk;

  scan_timing_gen u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .hires_i  (hires_i),
    .hz50_i   (hz50_i),
    .blank_o  (blank_o),
    .hsync_o  (hsync_o),
    .de_h_o   (de_h_o),
    .preload_o(preload_o),
    .load_o   (load_o),
    .std50_o  (std50_o)
  );

  // Observed vector: {blank, hsync, h, preload, load, std50}
  wire [5:0] obs = {blank_o, hsync_o, de_h_o, preload_o, load_o, std50_o};

  // {req[3:0], hires, hz50, position[9:0], expected[5:0]}
  localparam int NV = 29;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b1, 10'd0,   6'b100001},
    {4'd6, 1'b0, 1'b1, 10'd28,  6'b100001},
    {4'd6, 1'b0, 1'b1, 10'd29,  6'b000001},
    {4'd3, 1'b0, 1'b1, 10'd41,  6'b000111},
    {4'd5, 1'b0, 1'b1, 10'd42,  6'b000101},
    {4'd5, 1'b0, 1'b1, 10'd45,  6'b000111},
    {4'd5, 1'b0, 1'b1, 10'd56,  6'b000101},
    {4'd5, 1'b0, 1'b1, 10'd57,  6'b001001},
    {4'd7, 1'b0, 1'b1, 10'd376, 6'b001001},
    {4'd7, 1'b0, 1'b1, 10'd377, 6'b000001},
    {4'd6, 1'b0, 1'b1, 10'd449, 6'b100001},
    {4'd9, 1'b0, 1'b1, 10'd461, 6'b110001},
    {4'd9, 1'b0, 1'b1, 10'd501, 6'b100001},
    {4'd2, 1'b0, 1'b1, 10'd552, 6'b000001},
    {4'd2, 1'b0, 1'b1, 10'd553, 6'b000111},
    {4'd3, 1'b0, 1'b0, 10'd37,  6'b000111},
    {4'd5, 1'b0, 1'b0, 10'd53,  6'b001001},
    {4'd2, 1'b0, 1'b0, 10'd57,  6'b001000},
    {4'd7, 1'b0, 1'b0, 10'd372, 6'b001000},
    {4'd7, 1'b0, 1'b0, 10'd373, 6'b000000},
    {4'd9, 1'b0, 1'b0, 10'd461, 6'b110000},
    {4'd2, 1'b0, 1'b0, 10'd544, 6'b000000},
    {4'd2, 1'b0, 1'b0, 10'd545, 6'b000110},
    {4'd4, 1'b1, 1'b1, 10'd1,   6'b100111},
    {4'd5, 1'b1, 1'b1, 10'd4,   6'b100101},
    {4'd5, 1'b1, 1'b1, 10'd5,   6'b101001},
    {4'd8, 1'b1, 1'b1, 10'd165, 6'b100001},
    {4'd4, 1'b1, 1'b0, 10'd37,  6'b101001},
    {4'd2, 1'b1, 1'b0, 10'd57,  6'b101000}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s at position %0d: actual %b expected %b", req, pos, obs, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (cyc_en) pos++;
    @(negedge clk);
  endtask

  task automatic goto(input int p);
    while (pos < p) tick();
  endtask

  task automatic start(input logic hi, input logic f50);
    @(negedge clk);
    rst_n   = 1'b0;
    cyc_en  = 1'b0;
    hires_i = hi;
    hz50_i  = f50;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    pos    = 0;
    cyc_en = 1'b1;
  endtask

  initial begin
    #900000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    cyc_en  = 1'b0;
    hires_i = 1'b0;
    hz50_i  = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 during reset", 6'b100001);

    for (int i = 0; i < NV; i++) begin
      start(VEC[i][17], VEC[i][16]);
      goto(int'(VEC[i][15:6]));
      chk(req_name(VEC[i][21:18]), VEC[i][5:0]);
    end

    // R3: 50 Hz at position 40 after 60 Hz missed at 36: no prefill this line
    start(1'b0, 1'b1);
    goto(38); hz50_i = 1'b0;
    goto(41); chk("R3 switch to 60 after 36", 6'b000001);
    goto(60); chk("R3 no window, R2 latched 60", 6'b000000);

    // R3: prefill started at 36, a later 40 trigger does not restart it
    start(1'b0, 1'b0);
    goto(37); chk("R3 start at 36", 6'b000111);
    goto(38); hz50_i = 1'b1;
    goto(41); chk("R3 no restart", 6'b000111);
    goto(53); chk("R5 window after 4 words", 6'b001001);
    goto(57); chk("R2 latched 50", 6'b001001);
    goto(553); chk("R2 512-position line", 6'b000111);

    // R5: limit read live, switch to high resolution during prefill
    start(1'b0, 1'b1);
    goto(42); hires_i = 1'b1;
    goto(44); chk("R5 live limit, still busy", 6'b000101);
    goto(45); chk("R5 live limit, ends at word 1", 6'b001001);

    // R8: blanking set at 184 in high resolution
    start(1'b0, 1'b1);
    goto(100); hires_i = 1'b1;
    goto(165); chk("R8 window closes at 164", 6'b000001);
    goto(184); chk("R8 blank before 184", 6'b000001);
    goto(185); chk("R8 blank at 184", 6'b100001);

    // R7: window left open by a resolution detour closes at 460
    start(1'b0, 1'b1);
    goto(300); hires_i = 1'b1;
    goto(400); hires_i = 1'b0;
    goto(460); chk("R7 still open before 460", 6'b101001);
    goto(461); chk("R7 closes at 460", 6'b110001);

    // R10: enable low freezes outputs and position
    start(1'b0, 1'b1);
    goto(41);
    cyc_en = 1'b0;
    repeat (5) tick();
    chk("R10 frozen load strobe", 6'b000111);
    cyc_en = 1'b1;
    goto(56); chk("R10 resumed, last word", 6'b000101);
    goto(57); chk("R10 resumed, window open", 6'b001001);

    // R1: asynchronous reset in mid-line
    start(1'b0, 1'b1);
    goto(60);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", 6'b100001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule